// File: doc/BRIEF.md
# Bit-Manipulation Execute Unit

This unit is the execute stage for a set of bit-manipulation operations in a 32-bit core. Each cycle it takes one instruction word and the two source operand values. It decodes the opcode, funct3 and funct7 (or the upper immediate) fields. It then computes one of these operations:

- shifts that fill with ones
- left and right rotates
- AND with the complement of an operand
- population count and masked population count
- leading-zero and trailing-zero counts
- bit extract and bit deposit

Any encoding outside this set raises an illegal flag and gives a zero result.

The result and the flag are registered, so both appear one clock after the operands are presented. The core's pipeline control decides whether to use them. The unit holds no other state. The register file, the word-size variants and all pipeline control sit outside it.

Top module: `bmu_top`

## Requirements
- R1: The result and illegal outputs are registered and reflect the inputs sampled at the previous rising clock edge. While the synchronous reset is high, both outputs become zero at the clock edge.
- R2: Under opcode 0110011 with funct7 0010000, funct3 001 gives ~(~rs1 << n) and funct3 101 gives ~(~rs1 >> n). Vacated bit positions fill with ones, and n is rs2[4:0].
- R3: Under opcode 0010011 with instruction bits [31:25] = 0010000, funct3 001 and funct3 101 give the same ones-filling left and right shifts. Here n is the shamt field, instruction bits [24:20].
- R4: Under opcode 0110011 with funct7 0110000, funct3 001 rotates rs1 left and funct3 101 rotates rs1 right, by rs2[4:0]. The upper bits of rs2 are ignored.
- R5: Under opcode 0010011 with bits [31:25] = 0110000, funct3 101 rotates rs1 right by the shamt field. The same pattern with funct3 001 (a left-rotate immediate) is illegal.
- R6: Under opcode 0110011, funct3 111 with funct7 0100000 gives rs1 & ~rs2.
- R7: Under opcode 0110011, funct3 111 with funct7 0101000 gives the count of ones in rs1 & ~rs2. With rs2 equal to zero this equals the plain population count.
- R8: Under opcode 0110011 and funct3 010, funct7 0100000 gives the number of ones in rs1.
- R9: Under opcode 0110011 and funct3 010, funct7 0001000 gives the leading-zero count of rs1 and funct7 0101000 gives the trailing-zero count. Both return 32 for a zero operand.
- R10: The three unary counts in R8 and R9 require instruction bits [24:20] to be 00000. Any other value in that field is illegal.
- R11: Under opcode 0110011 and funct3 010, funct7 0010000 gathers the rs1 bits at the set positions of rs2. They are packed into the low result bits in ascending position order, and the remaining result bits are zero.
- R12: Under opcode 0110011 and funct3 010, funct7 0110000 scatters the low bits of rs1, in ascending order, to the set positions of rs2. All other result bits are zero.
- R13: Every other combination of opcode, funct3 and funct7/upper immediate sets illegal and gives a zero result. This includes the base shifts with funct7 0000000 and any opcode other than 0110011 and 0010011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| insn | input | 32 | Instruction word |
| src_a | input | 32 | First source operand (rs1 value) |
| src_b | input | 32 | Second source operand (rs2 value) |
| result | output | 32 | Registered result |
| illegal | output | 1 | Registered flag for unrecognised encodings |

## Verification
The bench targets the edges of each operation:

- **Shift amounts of 0 and 31.** A design that filled with zeros, or that used the wrong fill width, would show a wrong number of low or high ones.
- **Rotate amounts with upper rs2 bits set.** A design that used the full rs2 value as the amount would rotate by the wrong count.
- **Zero operand for the leading- and trailing-zero counts.** A priority encoder without a default would return 0 or 31 instead of 32.
- **Sparse and dense masks for extract and deposit.** These catch a reversed packing order, or a gather and scatter that were swapped.
- **Near-miss encodings.** These include a nonzero rs2 field on a count, the left-rotate immediate and the base shift. They show a decoder that matches too loosely, which would return a value where it should flag illegal.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [3:0] {
    BM_NONE, BM_SLO, BM_SRO, BM_ROL, BM_ROR, BM_ANDC,
    BM_PCNT, BM_MCNT, BM_CLZ, BM_CTZ, BM_BEXT, BM_BDEP
  } bm_op_e;

  typedef struct packed {
    bm_op_e op;
    logic   amt_imm;
    logic   bad;
  } bm_dec_t;

  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;
  localparam logic [2:0] F3_SL   = 3'b001;
  localparam logic [2:0] F3_SR   = 3'b101;
  localparam logic [2:0] F3_AND  = 3'b111;
  localparam logic [2:0] F3_CNT  = 3'b010;
  localparam logic [6:0] F7_ONES = 7'b0010000;
  localparam logic [6:0] F7_ROT  = 7'b0110000;
  localparam logic [6:0] F7_NAND = 7'b0100000;
  localparam logic [6:0] F7_CLZ  = 7'b0001000;
  localparam logic [6:0] F7_CTZ  = 7'b0101000;
endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
  import bmu_pkg::*;
(
  input  logic [31:0] insn,
  output bm_dec_t     dec
);
  logic [6:0] opc, f7;
  logic [2:0] f3;
  logic       rs2_zero;

  assign opc      = insn[6:0];
  assign f3       = insn[14:12];
  assign f7       = insn[31:25];
  assign rs2_zero = (insn[24:20] == 5'd0);

  always_comb begin
    dec.op      = BM_NONE;
    dec.amt_imm = 1'b0;
    if (opc == OPC_REG) begin
      unique case (f3)
        F3_SL:  if (f7 == F7_ONES) dec.op = BM_SLO;
                else if (f7 == F7_ROT) dec.op = BM_ROL;
        F3_SR:  if (f7 == F7_ONES) dec.op = BM_SRO;
                else if (f7 == F7_ROT) dec.op = BM_ROR;
        F3_AND: if (f7 == F7_NAND) dec.op = BM_ANDC;
                else if (f7 == F7_CTZ) dec.op = BM_MCNT;
        F3_CNT: begin
          if (f7 == F7_NAND && rs2_zero) dec.op = BM_PCNT;
          else if (f7 == F7_CLZ && rs2_zero) dec.op = BM_CLZ;
          else if (f7 == F7_CTZ && rs2_zero) dec.op = BM_CTZ;
          else if (f7 == F7_ONES) dec.op = BM_BEXT;
          else if (f7 == F7_ROT) dec.op = BM_BDEP;
        end
        default: dec.op = BM_NONE;
      endcase
    end else if (opc == OPC_IMM) begin
      dec.amt_imm = 1'b1;
      if (f3 == F3_SL && f7 == F7_ONES) dec.op = BM_SLO;
      else if (f3 == F3_SR && f7 == F7_ONES) dec.op = BM_SRO;
      else if (f3 == F3_SR && f7 == F7_ROT) dec.op = BM_ROR;
    end
    dec.bad = (dec.op == BM_NONE);
  end
endmodule

// File: rtl/bmu_count.sv
module bmu_count #(
  parameter int XLEN = 32,
  localparam int CW  = $clog2(XLEN) + 1
) (
  input  logic [XLEN-1:0] val,
  input  logic [XLEN-1:0] mask,
  output logic [CW-1:0]   ones,
  output logic [CW-1:0]   lead,
  output logic [CW-1:0]   trail
);
  logic [XLEN-1:0] kept;
  assign kept = val & ~mask;

  always_comb begin
    ones = '0;
    for (int i = 0; i < XLEN; i++)
      ones = ones + {{(CW-1){1'b0}}, kept[i]};
  end

  always_comb begin
    lead = CW'(XLEN);
    for (int i = 0; i < XLEN; i++)
      if (val[i]) lead = CW'(XLEN - 1 - i);
  end

  always_comb begin
    trail = CW'(XLEN);
    for (int i = XLEN - 1; i >= 0; i--)
      if (val[i]) trail = CW'(i);
  end
endmodule

// File: rtl/bmu_extdep.sv
module bmu_extdep #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] val,
  input  logic [XLEN-1:0] sel,
  output logic [XLEN-1:0] gathered,
  output logic [XLEN-1:0] scattered
);
  logic [SHW:0] gk, sk;

  always_comb begin
    gathered = '0;
    gk       = '0;
    for (int i = 0; i < XLEN; i++)
      if (sel[i]) begin
        gathered[gk[SHW-1:0]] = val[i];
        gk = gk + 1'b1;
      end
  end

  always_comb begin
    scattered = '0;
    sk        = '0;
    for (int i = 0; i < XLEN; i++)
      if (sel[i]) begin
        scattered[i] = val[sk[SHW-1:0]];
        sk = sk + 1'b1;
      end
  end
endmodule

// File: rtl/bmu_top.sv
module bmu_top
  import bmu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] result,
  output logic            illegal
);
  localparam int SHW = $clog2(XLEN);
  localparam int CW  = SHW + 1;

  bm_dec_t         dec;
  logic [SHW-1:0]  amt;
  logic [XLEN-1:0] cmask, gathered, scattered, res_d;
  logic [CW-1:0]   ones, lead, trail;
  logic [2*XLEN-1:0] rol_w, ror_w;

  bmu_decode u_dec (.insn(insn), .dec(dec));

  assign amt   = dec.amt_imm ? insn[20 +: SHW] : src_b[SHW-1:0];
  assign cmask = (dec.op == BM_MCNT) ? src_b : '0;
  assign rol_w = {src_a, src_a} << amt;
  assign ror_w = {src_a, src_a} >> amt;

  bmu_count #(.XLEN(XLEN)) u_cnt (
    .val(src_a), .mask(cmask), .ones(ones), .lead(lead), .trail(trail));

  bmu_extdep #(.XLEN(XLEN)) u_xd (
    .val(src_a), .sel(src_b), .gathered(gathered), .scattered(scattered));

  always_comb begin
    unique case (dec.op)
      BM_SLO:  res_d = ~((~src_a) << amt);
      BM_SRO:  res_d = ~((~src_a) >> amt);
      BM_ROL:  res_d = rol_w[2*XLEN-1:XLEN];
      BM_ROR:  res_d = ror_w[XLEN-1:0];
      BM_ANDC: res_d = src_a & ~src_b;
      BM_PCNT, BM_MCNT: res_d = XLEN'(ones);
      BM_CLZ:  res_d = XLEN'(lead);
      BM_CTZ:  res_d = XLEN'(trail);
      BM_BEXT: res_d = gathered;
      BM_BDEP: res_d = scattered;
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      illegal <= 1'b0;
    end else begin
      result  <= res_d;
      illegal <= dec.bad;
    end
  end
endmodule

// File: rtl/bmu_chk.sv
module bmu_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [31:0]     insn,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic [XLEN-1:0] result,
  input logic            illegal
);
  logic is_reg, is_andc, is_pcnt, is_clz, is_mcnt;
  assign is_reg  = insn[6:0] == 7'b0110011;
  assign is_andc = is_reg && insn[14:12] == 3'b111 && insn[31:25] == 7'b0100000;
  assign is_mcnt = is_reg && insn[14:12] == 3'b111 && insn[31:25] == 7'b0101000;
  assign is_pcnt = is_reg && insn[14:12] == 3'b010 && insn[31:25] == 7'b0100000
                   && insn[24:20] == 5'd0;
  assign is_clz  = is_reg && insn[14:12] == 3'b010 && insn[31:25] == 7'b0001000
                   && insn[24:20] == 5'd0;

  // R13
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> result == '0);

  // R13
  foreign_opc_chk: assert property (@(posedge clk) disable iff (rst)
    (insn[6:0] != 7'b0110011 && insn[6:0] != 7'b0010011) |=> illegal);

  // R6
  andc_value_chk: assert property (@(posedge clk) disable iff (rst)
    is_andc |=> (!illegal && result == ($past(src_a) & ~$past(src_b))));

  // R8
  pcnt_value_chk: assert property (@(posedge clk) disable iff (rst)
    is_pcnt |=> result == XLEN'($countones($past(src_a))));

  // R7
  mcnt_value_chk: assert property (@(posedge clk) disable iff (rst)
    is_mcnt |=> result == XLEN'($countones($past(src_a) & ~$past(src_b))));

  // R9
  clz_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (is_clz && src_a == '0) |=> result == XLEN'(XLEN));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (result == '0 && !illegal));
endmodule

bind bmu_top bmu_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/bmu_top_test.sv
module bmu_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn = 32'h0, a = 32'h0, b = 32'h0;
  logic [31:0] result;
  logic        illegal;
  int checks = 0, fails = 0;

  bmu_top uut (.clk(clk), .rst(rst), .insn(insn), .src_a(a), .src_b(b),
               .result(result), .illegal(illegal));

  always #5 clk = ~clk;

  function automatic logic [31:0] rt(logic [6:0] f7, logic [4:0] rs2f, logic [2:0] f3);
    return {f7, rs2f, 5'd1, f3, 5'd3, 7'b0110011};
  endfunction
  function automatic logic [31:0] it(logic [6:0] hi, logic [4:0] sh, logic [2:0] f3);
    return {hi, sh, 5'd1, f3, 5'd3, 7'b0010011};
  endfunction

  function automatic logic [31:0] m_rol(logic [31:0] x, int n);
    logic [31:0] y = x;
    for (int i = 0; i < n; i++) y = {y[30:0], y[31]};
    return y;
  endfunction
  function automatic logic [31:0] m_ror(logic [31:0] x, int n);
    logic [31:0] y = x;
    for (int i = 0; i < n; i++) y = {y[0], y[31:1]};
    return y;
  endfunction
  function automatic logic [31:0] m_pop(logic [31:0] x);
    int c = 0;
    for (int i = 0; i < 32; i++) if (x[i]) c++;
    return 32'(c);
  endfunction
  function automatic logic [31:0] m_clz(logic [31:0] x);
    int c = 0;
    for (int i = 31; i >= 0; i--) begin
      if (x[i]) break;
      c++;
    end
    return 32'(c);
  endfunction
  function automatic logic [31:0] m_ctz(logic [31:0] x);
    int c = 0;
    for (int i = 0; i < 32; i++) begin
      if (x[i]) break;
      c++;
    end
    return 32'(c);
  endfunction
  function automatic logic [31:0] m_ext(logic [31:0] x, logic [31:0] m);
    logic [31:0] y = 0;
    int j = 0;
    for (int i = 0; i < 32; i++) if (m[i]) begin y[j] = x[i]; j++; end
    return y;
  endfunction
  function automatic logic [31:0] m_dep(logic [31:0] x, logic [31:0] m);
    logic [31:0] y = 0;
    int j = 0;
    for (int i = 0; i < 32; i++) if (m[i]) begin y[i] = x[j]; j++; end
    return y;
  endfunction

  task automatic chk(string req, logic [31:0] exp_r, logic exp_i);
    checks++;
    if (result !== exp_r || illegal !== exp_i) begin
      fails++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
               req, result, illegal, exp_r, exp_i);
    end
  endtask

  task automatic run(logic [31:0] w, logic [31:0] x, logic [31:0] y);
    @(negedge clk);
    insn = w; a = x; b = y;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; insn = rt(7'b0100000, 5'd2, 3'b111); a = 32'hFFFF_0000; b = 32'h0;
    @(posedge clk); #1;
    chk("R1 reset with legal op", 32'h0, 1'b0);
    @(negedge clk); insn = 32'h0;
    @(posedge clk); #1;
    chk("R1 reset with illegal op", 32'h0, 1'b0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_shift_ones();
    run(rt(7'b0010000, 5'd2, 3'b001), 32'h0000_00F0, 32'hFFFF_FFE4);
    chk("R2 SLO by 4", 32'h0000_0F0F, 1'b0);
    run(rt(7'b0010000, 5'd2, 3'b101), 32'h1234_5678, 32'd31);
    chk("R2 SRO by 31", 32'hFFFF_FFFE, 1'b0);
    run(rt(7'b0010000, 5'd2, 3'b001), 32'hA5A5_A5A5, 32'd0);
    chk("R2 SLO by 0", 32'hA5A5_A5A5, 1'b0);
    run(it(7'b0010000, 5'd8, 3'b001), 32'h0000_1234, 32'd0);
    chk("R3 SLOI by 8", 32'h0012_34FF, 1'b0);
    run(it(7'b0010000, 5'd12, 3'b101), 32'h8765_4321, 32'd3);
    chk("R3 SROI by 12", 32'hFFF8_7654, 1'b0);
  endtask

  task automatic t_rotates();
    run(rt(7'b0110000, 5'd2, 3'b001), 32'h8000_0001, 32'h0000_0021);
    chk("R4 ROL ignores upper rs2 bits", m_rol(32'h8000_0001, 1), 1'b0);
    run(rt(7'b0110000, 5'd2, 3'b101), 32'h1234_5678, 32'd8);
    chk("R4 ROR by 8", m_ror(32'h1234_5678, 8), 1'b0);
    run(rt(7'b0110000, 5'd2, 3'b101), 32'hDEAD_BEEF, 32'd31);
    chk("R4 ROR by 31", m_ror(32'hDEAD_BEEF, 31), 1'b0);
    run(it(7'b0110000, 5'd4, 3'b101), 32'hCAFE_F00D, 32'd9);
    chk("R5 RORI by 4", m_ror(32'hCAFE_F00D, 4), 1'b0);
    run(it(7'b0110000, 5'd4, 3'b001), 32'hCAFE_F00D, 32'd9);
    chk("R5 left-rotate immediate illegal", 32'h0, 1'b1);
  endtask

  task automatic t_logic_counts();
    run(rt(7'b0100000, 5'd2, 3'b111), 32'hF0F0_FFFF, 32'h00FF_0F0F);
    chk("R6 ANDC", 32'hF000_F0F0, 1'b0);
    run(rt(7'b0101000, 5'd2, 3'b111), 32'hFFFF_FFFF, 32'h0000_FFFF);
    chk("R7 masked count", 32'd16, 1'b0);
    run(rt(7'b0101000, 5'd2, 3'b111), 32'h1357_9BDF, 32'h0);
    chk("R7 masked count with zero mask", m_pop(32'h1357_9BDF), 1'b0);
    run(rt(7'b0100000, 5'd0, 3'b010), 32'h1357_9BDF, 32'hFFFF_FFFF);
    chk("R8 PCNT", m_pop(32'h1357_9BDF), 1'b0);
    run(rt(7'b0001000, 5'd0, 3'b010), 32'h0001_0000, 32'h0);
    chk("R9 CLZ", m_clz(32'h0001_0000), 1'b0);
    run(rt(7'b0001000, 5'd0, 3'b010), 32'h0, 32'h0);
    chk("R9 CLZ of zero", 32'd32, 1'b0);
    run(rt(7'b0101000, 5'd0, 3'b010), 32'h0000_0A00, 32'h0);
    chk("R9 CTZ", m_ctz(32'h0000_0A00), 1'b0);
    run(rt(7'b0101000, 5'd0, 3'b010), 32'h0, 32'h0);
    chk("R9 CTZ of zero", 32'd32, 1'b0);
    run(rt(7'b0100000, 5'd3, 3'b010), 32'hFFFF_FFFF, 32'h0);
    chk("R10 PCNT with rs2 field set", 32'h0, 1'b1);
    run(rt(7'b0001000, 5'd1, 3'b010), 32'h0, 32'h0);
    chk("R10 CLZ with rs2 field set", 32'h0, 1'b1);
  endtask

  task automatic t_extdep();
    run(rt(7'b0010000, 5'd2, 3'b010), 32'hA5C3_5A3C, 32'hF000_000F);
    chk("R11 BEXT sparse", m_ext(32'hA5C3_5A3C, 32'hF000_000F), 1'b0);
    run(rt(7'b0010000, 5'd2, 3'b010), 32'h8000_0001, 32'h8000_0000);
    chk("R11 BEXT top bit to bit 0", 32'h1, 1'b0);
    run(rt(7'b0110000, 5'd2, 3'b010), 32'h0000_0005, 32'h8001_0010);
    chk("R12 BDEP sparse", 32'h8000_0010, 1'b0);
    run(rt(7'b0110000, 5'd2, 3'b010), 32'h1234_5678, 32'hFFFF_FFFF);
    chk("R12 BDEP full mask", 32'h1234_5678, 1'b0);
    run(rt(7'b0110000, 5'd2, 3'b010), 32'hDEAD_BEEF, 32'h0F0F_3300);
    chk("R12 BDEP mixed", m_dep(32'hDEAD_BEEF, 32'h0F0F_3300), 1'b0);
  endtask

  task automatic t_illegal();
    run(rt(7'b0000000, 5'd2, 3'b001), 32'h1, 32'd3);
    chk("R13 base shift illegal", 32'h0, 1'b1);
    run(rt(7'b0000000, 5'd2, 3'b000), 32'h1, 32'h1);
    chk("R13 base add illegal", 32'h0, 1'b1);
    run({17'h0, 3'b010, 5'd3, 7'b0000011}, 32'h1, 32'h1);
    chk("R13 load opcode illegal", 32'h0, 1'b1);
    run(rt(7'b0010000, 5'd2, 3'b111), 32'hFFFF_FFFF, 32'h0);
    chk("R13 unknown funct7 under AND", 32'h0, 1'b1);
    run(rt(7'b0010000, 5'd2, 3'b001), 32'h0000_0001, 32'd1);
    chk("R13 recovery after illegal (SLO by 1)", 32'h0000_0003, 1'b0);
  endtask

  initial begin
    t_reset();
    t_shift_ones();
    t_rotates();
    t_logic_counts();
    t_extdep();
    t_illegal();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule